// File: doc/BRIEF.md
# CPU Instruction and Data Memory Port Controller

This block links a two-stage CPU core to a single 32-bit memory bus. In the first pipeline stage it presents the program counter on the bus and fetches the next instruction word. It keeps that word in an opcode register for the second stage, where decode, execute and writeback take place. An instruction that does not touch memory finishes in one clock. A load or store takes two clocks. The first clock is the ordinary fetch. In the second clock the bus carries the data address, and the block steers the data lanes.

The controller is a two-state machine. `ST_FETCH` presents the program counter and `ST_DATA` presents the data address. A setup flag marks the first fetch after reset. Four transitions are named:
- `FIRST_FETCH`: `ST_FETCH` with the flag clear back to `ST_FETCH`, which sets the flag.
- `PLAIN_STEP`: `ST_FETCH` back to `ST_FETCH` for a non-memory instruction.
- `ENTER_DATA`: `ST_FETCH` to `ST_DATA` for a load or store.
- `LEAVE_DATA`: `ST_DATA` back to `ST_FETCH`.

During `ENTER_DATA` the fetched word is parked in a second register, the next-opcode register. It moves into the current opcode register when `LEAVE_DATA` fires. While the memory pause input is high, nothing advances and the core is told to stall.

Byte and halfword accesses are placed on byte lanes by the low address bits. The lane mapping is chosen by a two-bit configuration parameter. Stores replicate their data onto every lane. Loads pick out the addressed lanes and extend them to the full width.

Top module: `memctl_top`

## Requirements
- R1: While reset is held, the outputs are: `opcode` is the no-op word (all zeros), `stall` is 1, `mem_we` is 0 and `mem_be` is 0.
- R2: In the first cycle after reset, `mem_addr` equals `pc_addr` and `stall` is 1. At the following edge the fetched `mem_rdata` becomes `opcode`, and `stall` then drops.
- R3: For a non-memory `op_kind` (0, or any value from 9 to 15), the cycle has these values: `stall` is 0, `mem_addr` is `pc_addr`, and `opcode` takes the fetched word at the next edge.
- R4: A load or store has the `op_kind` codes 1=byte signed load, 2=byte unsigned load, 3=halfword signed load, 4=halfword unsigned load, 5=word load, 6=byte store, 7=halfword store, 8=word store. It takes two cycles. The first cycle presents `pc_addr` with `stall` 1. The second cycle presents `data_addr` with `stall` 0. The word fetched in the first cycle becomes `opcode` after the second.
- R5: While `mem_pause` is 1, `stall` is 1, `opcode` keeps its value and the state does not advance.
- R6: A byte store (code 6) copies `store_data[7:0]` onto all four lanes. It asserts exactly one `mem_be` bit, the bit of the lane given by R10.
- R7: A halfword store (code 7) copies `store_data[15:0]` onto both halves. It asserts `mem_be` = 1100 for the upper half (bits 31:16) or 0011 for the lower half, as chosen by R10.
- R8: A word access (codes 5 and 8) asserts `mem_be` = 1111. A word store drives `store_data` unchanged.
- R9: A load, in its second cycle, drives `load_valid` = 1 and asserts the `mem_be` lanes it reads. Its `load_data` is the addressed byte or half of `mem_rdata`, sign-extended for codes 1 and 3 and zero-extended for codes 2 and 4. A word load passes `mem_rdata` whole.
- R10: Lane mapping depends on `ENDIAN_CFG`, where `mem_be` bit i covers bits 8i+7..8i and off = `data_addr[1:0]`.
  - With `ENDIAN_CFG` = 00 (big-endian), the byte lane is 3-off, and the upper half is used when `data_addr[1]` = 0.
  - With `ENDIAN_CFG` = 11 (little-endian), the byte lane is off, and the upper half is used when `data_addr[1]` = 1.
- R11: `mem_we` is 1 only in the second cycle of a store. In fetch cycles `mem_be` is 0, `mem_wdata` is 0, `load_valid` is 0 and `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_addr | input | AW | Instruction fetch address |
| op_kind | input | 4 | Memory access type of the executing instruction |
| data_addr | input | AW | Load/store byte address |
| store_data | input | DW | Store value, right-aligned |
| opcode | output | DW | Instruction word being executed |
| load_data | output | DW | Extended load result |
| load_valid | output | 1 | load_data is valid this cycle |
| stall | output | 1 | Core must hold its state |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data |
| mem_be | output | DW/8 | Byte-lane selects |
| mem_we | output | 1 | Write strobe |
| mem_pause | input | 1 | Memory wait request |

## Verification
Every access code is swept against all four low address offsets, on a big-endian and a little-endian instance at once. This separates the lane formulas 3-off and off, the upper-half choice, and byte accesses from halfword accesses. The read word puts a negative byte in the two upper lanes and positive bytes in the two lower lanes, so a wrong sign or zero extension shows up at some offset. A pause is inserted inside the data cycle at one offset per code, to show that the opcode and the data-phase bus stay frozen. Fetch words change on every instruction, so a parked opcode that is lost or released early is caught.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

    typedef enum logic [3:0] {
        ACC_NONE = 4'd0,
        ACC_LB   = 4'd1,
        ACC_LBU  = 4'd2,
        ACC_LH   = 4'd3,
        ACC_LHU  = 4'd4,
        ACC_LW   = 4'd5,
        ACC_SB   = 4'd6,
        ACC_SH   = 4'd7,
        ACC_SW   = 4'd8
    } acc_e;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_DATA  = 1'b1
    } st_e;

    function automatic logic kind_is_mem(logic [3:0] k);
        return (k >= 4'd1) && (k <= 4'd8);
    endfunction

    function automatic logic kind_is_load(logic [3:0] k);
        return (k >= 4'd1) && (k <= 4'd5);
    endfunction

endpackage

// File: rtl/memctl_fsm.sv
module memctl_fsm
    import memctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pause,
    input  logic mem_op,
    output st_e  st,
    output logic setup_done,
    output logic stall,
    output logic cur_from_fetch,
    output logic cur_from_next,
    output logic next_capture,
    output logic data_phase
);

    st_e  st_nx;
    logic done_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_FETCH;
            setup_done <= 1'b0;
        end else begin
            st         <= st_nx;
            setup_done <= done_nx;
        end
    end

    // Next state and control outputs
    always_comb begin
        st_nx          = st;
        done_nx        = setup_done;
        stall          = pause;
        cur_from_fetch = 1'b0;
        cur_from_next  = 1'b0;
        next_capture   = 1'b0;
        data_phase     = 1'b0;
        unique case (st)
            ST_FETCH: begin
                if (!setup_done) begin
                    // FIRST_FETCH
                    stall          = 1'b1;
                    cur_from_fetch = !pause;
                    done_nx        = setup_done | !pause;
                end else if (mem_op) begin
                    // ENTER_DATA
                    stall        = 1'b1;
                    next_capture = !pause;
                    if (!pause) st_nx = ST_DATA;
                end else begin
                    // PLAIN_STEP
                    cur_from_fetch = !pause;
                end
            end
            ST_DATA: begin
                // LEAVE_DATA
                data_phase    = 1'b1;
                cur_from_next = !pause;
                if (!pause) st_nx = ST_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/memctl_opregs.sv
module memctl_opregs #(
    parameter int          DW       = 32,
    parameter logic [DW-1:0] NOP_WORD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] fetch_word,
    input  logic          cur_from_fetch,
    input  logic          cur_from_next,
    input  logic          next_capture,
    output logic [DW-1:0] opcode
);

    logic [DW-1:0] next_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode <= NOP_WORD;
            next_q <= NOP_WORD;
        end else begin
            if (cur_from_fetch)
                opcode <= fetch_word;
            else if (cur_from_next)
                opcode <= next_q;
            if (next_capture)
                next_q <= fetch_word;
        end
    end

endmodule

// File: rtl/memctl_lanes.sv
module memctl_lanes
    import memctl_pkg::*;
#(
    parameter int DW     = 32,
    parameter bit LITTLE = 1'b0,
    localparam int LANES  = DW / 8,
    localparam int OFFW   = $clog2(LANES),
    localparam int HALVES = LANES / 2
) (
    input  logic             data_phase,
    input  logic [3:0]       kind,
    input  logic [OFFW-1:0]  off,
    input  logic [DW-1:0]    store_data,
    output logic [LANES-1:0] be,
    output logic [DW-1:0]    wdata,
    output logic             we,
    output logic [OFFW-1:0]  byte_lane,
    output logic [OFFW-2:0]  half_idx
);

    always_comb begin
        byte_lane = LITTLE ? off : (OFFW'(LANES - 1) - off);
        half_idx  = LITTLE ? off[OFFW-1:1]
                           : ((OFFW-1)'(HALVES - 1) - off[OFFW-1:1]);
    end

    always_comb begin
        be    = '0;
        wdata = '0;
        we    = 1'b0;
        if (data_phase) begin
            case (acc_e'(kind))
                ACC_LB, ACC_LBU: be = LANES'(1) << byte_lane;
                ACC_LH, ACC_LHU: be = LANES'(2'b11) << {half_idx, 1'b0};
                ACC_LW:          be = '1;
                ACC_SB: begin
                    be    = LANES'(1) << byte_lane;
                    wdata = {LANES{store_data[7:0]}};
                    we    = 1'b1;
                end
                ACC_SH: begin
                    be    = LANES'(2'b11) << {half_idx, 1'b0};
                    wdata = {HALVES{store_data[15:0]}};
                    we    = 1'b1;
                end
                ACC_SW: begin
                    be    = '1;
                    wdata = store_data;
                    we    = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/memctl_loadext.sv
module memctl_loadext
    import memctl_pkg::*;
#(
    parameter int DW = 32,
    localparam int LANES  = DW / 8,
    localparam int OFFW   = $clog2(LANES),
    localparam int HALVES = LANES / 2
) (
    input  logic            data_phase,
    input  logic [3:0]      kind,
    input  logic [OFFW-1:0] byte_lane,
    input  logic [OFFW-2:0] half_idx,
    input  logic [DW-1:0]   rdata,
    output logic [DW-1:0]   load_data,
    output logic            load_valid
);

    logic [7:0]  lane_b [LANES];
    logic [15:0] lane_h [HALVES];

    for (genvar g = 0; g < LANES; g++) begin : g_blane
        assign lane_b[g] = rdata[8*g +: 8];
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_hlane
        assign lane_h[h] = rdata[16*h +: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b      = lane_b[byte_lane];
        sel_h      = lane_h[half_idx];
        load_data  = '0;
        load_valid = data_phase && kind_is_load(kind);
        if (data_phase) begin
            case (acc_e'(kind))
                ACC_LB:  load_data = {{(DW-8){sel_b[7]}}, sel_b};
                ACC_LBU: load_data = {{(DW-8){1'b0}}, sel_b};
                ACC_LH:  load_data = {{(DW-16){sel_h[15]}}, sel_h};
                ACC_LHU: load_data = {{(DW-16){1'b0}}, sel_h};
                ACC_LW:  load_data = rdata;
                default: load_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/memctl_top.sv
module memctl_top
    import memctl_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter logic [1:0]    ENDIAN_CFG = 2'b00,
    parameter logic [DW-1:0] NOP_WORD   = '0,
    localparam int LANES  = DW / 8,
    localparam int OFFW   = $clog2(LANES),
    localparam bit LITTLE = (ENDIAN_CFG == 2'b11)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    pc_addr,
    input  logic [3:0]       op_kind,
    input  logic [AW-1:0]    data_addr,
    input  logic [DW-1:0]    store_data,
    output logic [DW-1:0]    opcode,
    output logic [DW-1:0]    load_data,
    output logic             load_valid,
    output logic             stall,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [LANES-1:0] mem_be,
    output logic             mem_we,
    input  logic             mem_pause
);

    st_e             fsm_st;
    logic            setup_done;
    logic            cur_from_fetch;
    logic            cur_from_next;
    logic            next_capture;
    logic            data_phase;
    logic [OFFW-1:0] byte_lane;
    logic [OFFW-2:0] half_idx;

    memctl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pause          (mem_pause),
        .mem_op         (kind_is_mem(op_kind)),
        .st             (fsm_st),
        .setup_done     (setup_done),
        .stall          (stall),
        .cur_from_fetch (cur_from_fetch),
        .cur_from_next  (cur_from_next),
        .next_capture   (next_capture),
        .data_phase     (data_phase)
    );

    memctl_opregs #(.DW(DW), .NOP_WORD(NOP_WORD)) u_ops (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_word     (mem_rdata),
        .cur_from_fetch (cur_from_fetch),
        .cur_from_next  (cur_from_next),
        .next_capture   (next_capture),
        .opcode         (opcode)
    );

    memctl_lanes #(.DW(DW), .LITTLE(LITTLE)) u_lanes (
        .data_phase (data_phase),
        .kind       (op_kind),
        .off        (data_addr[OFFW-1:0]),
        .store_data (store_data),
        .be         (mem_be),
        .wdata      (mem_wdata),
        .we         (mem_we),
        .byte_lane  (byte_lane),
        .half_idx   (half_idx)
    );

    memctl_loadext #(.DW(DW)) u_ldx (
        .data_phase (data_phase),
        .kind       (op_kind),
        .byte_lane  (byte_lane),
        .half_idx   (half_idx),
        .rdata      (mem_rdata),
        .load_data  (load_data),
        .load_valid (load_valid)
    );

    assign mem_addr = data_phase ? data_addr : pc_addr;

endmodule

// File: rtl/memctl_chk.sv
module memctl_chk #(
    parameter int DW = 32,
    localparam int LANES = DW / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st,
    input logic             setup_done,
    input logic [3:0]       op_kind,
    input logic             mem_pause,
    input logic             stall,
    input logic             mem_we,
    input logic [LANES-1:0] mem_be,
    input logic [DW-1:0]    opcode
);

    p_fetch_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b0) |-> (mem_be == '0 && !mem_we));

    p_we_unstalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_pause) |-> !stall);

    p_enter_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b0 && setup_done && op_kind >= 4'd1 && op_kind <= 4'd8 && !mem_pause)
        |=> (st == 1'b1));

    p_leave_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && !mem_pause) |=> (st == 1'b0));

    p_pause_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pause |=> $stable(opcode));

    p_byte_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && (op_kind == 4'd6 || op_kind == 4'd1 || op_kind == 4'd2))
        |-> $countones(mem_be) == 1);

    p_half_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && (op_kind == 4'd7 || op_kind == 4'd3 || op_kind == 4'd4))
        |-> $countones(mem_be) == 2);

    p_word_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 1'b1 && (op_kind == 4'd5 || op_kind == 4'd8)) |-> (&mem_be));

endmodule

bind memctl_top memctl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (fsm_st),
    .setup_done (setup_done),
    .op_kind    (op_kind),
    .mem_pause  (mem_pause),
    .stall      (stall),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .opcode     (opcode)
);

// File: tb/sim_memctl_top.sv
module sim_memctl_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_addr = '0;
    logic [3:0]  op_kind = '0;
    logic [31:0] data_addr = '0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_pause = 1'b0;

    logic [31:0] op0, ld0, ma0, wd0, op1, ld1, ma1, wd1;
    logic        lv0, st0, we0, lv1, st1, we1;
    logic [3:0]  be0, be1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memctl_top #(.ENDIAN_CFG(2'b00)) u0 (
        .clk(clk), .rst_n(rst_n), .pc_addr(pc_addr), .op_kind(op_kind),
        .data_addr(data_addr), .store_data(store_data), .opcode(op0),
        .load_data(ld0), .load_valid(lv0), .stall(st0), .mem_addr(ma0),
        .mem_wdata(wd0), .mem_rdata(mem_rdata), .mem_be(be0), .mem_we(we0),
        .mem_pause(mem_pause)
    );

    memctl_top #(.ENDIAN_CFG(2'b11)) u1 (
        .clk(clk), .rst_n(rst_n), .pc_addr(pc_addr), .op_kind(op_kind),
        .data_addr(data_addr), .store_data(store_data), .opcode(op1),
        .load_data(ld1), .load_valid(lv1), .stall(st1), .mem_addr(ma1),
        .mem_wdata(wd1), .mem_rdata(mem_rdata), .mem_be(be1), .mem_we(we1),
        .mem_pause(mem_pause)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int lane_of(int off, bit little);
        return little ? off : 3 - off;
    endfunction

    function automatic bit upper_of(int off, bit little);
        bit a1 = (off & 2) != 0;
        return little ? a1 : !a1;
    endfunction

    function automatic logic [3:0] e_be(int k, int off, bit little);
        case (k)
            1, 2, 6: return 4'(1 << lane_of(off, little));
            3, 4, 7: return upper_of(off, little) ? 4'hC : 4'h3;
            5, 8:    return 4'hF;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] e_wd(int k, logic [31:0] sd);
        case (k)
            6: return {4{sd[7:0]}};
            7: return {2{sd[15:0]}};
            8: return sd;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] e_ld(int k, int off, bit little, logic [31:0] d);
        logic [7:0]  b = 8'((d >> (8 * lane_of(off, little))) & 32'hFF);
        logic [15:0] h = upper_of(off, little) ? d[31:16] : d[15:0];
        case (k)
            1: return {{24{b[7]}}, b};
            2: return {24'h0, b};
            3: return {{16{h[15]}}, h};
            4: return {16'h0, h};
            5: return d;
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] prev_op;
        logic [31:0] pc;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 opcode u0", op0, 32'h0);
        chk("R1 opcode u1", op1, 32'h0);
        chk("R1 stall", {st1, st0}, 32'h3);
        chk("R1 we", {we1, we0}, 32'h0);
        chk("R1 be", {be1, be0}, 32'h0);

        rst_n = 1'b1;
        pc_addr = 32'h0000_0100;
        mem_rdata = 32'hA000_0001;
        #1;
        chk("R2 addr u0", ma0, 32'h0000_0100);
        chk("R2 addr u1", ma1, 32'h0000_0100);
        chk("R2 stall", {st1, st0}, 32'h3);
        step();
        chk("R2 opcode u0", op0, 32'hA000_0001);
        chk("R2 opcode u1", op1, 32'hA000_0001);
        #1;
        chk("R2 stall drop", {st1, st0}, 32'h0);

        // R5: pause in a plain fetch
        mem_pause = 1'b1;
        mem_rdata = 32'hDEAD_BEEF;
        #1;
        chk("R5 stall", {st1, st0}, 32'h3);
        step();
        chk("R5 opcode held", op0, 32'hA000_0001);
        chk("R5 opcode held u1", op1, 32'hA000_0001);
        mem_pause = 1'b0;

        // R3: non-memory instructions, including unused codes
        pc = 32'h0000_0104;
        for (int k = 9; k <= 16; k++) begin
            op_kind = (k == 16) ? 4'd0 : 4'(k);
            pc_addr = pc;
            mem_rdata = 32'hB000_0000 | 32'(k);
            #1;
            chk("R3 stall", {st1, st0}, 32'h0);
            chk("R3 addr", ma0, pc);
            chk("R11 be fetch", {be1, be0}, 32'h0);
            step();
            chk("R3 opcode", op0, 32'hB000_0000 | 32'(k));
            chk("R3 opcode u1", op1, 32'hB000_0000 | 32'(k));
            pc += 4;
        end
        prev_op = 32'hB000_0010;

        // R4, R6..R10: every access code at every offset
        for (int k = 1; k <= 8; k++) begin
            for (int off = 0; off < 4; off++) begin
                int          i  = (k - 1) * 4 + off;
                logic [31:0] fw = 32'h0F00_0000 | 32'(i);
                logic [31:0] sd = 32'hC3A5_5A3C ^ (32'(i) * 32'h0101);
                logic [31:0] dw = {8'h80 ^ 8'(i), 8'hFF, 8'h7F, 8'h01 + 8'(i)};
                op_kind    = 4'(k);
                data_addr  = 32'h0000_2000 + 32'(off);
                store_data = sd;
                pc_addr    = pc;
                mem_rdata  = fw;
                #1;
                chk("R4 opcode before", op0, prev_op);
                chk("R4 fetch addr", ma1, pc);
                chk("R4 first stall", {st1, st0}, 32'h3);
                chk("R11 fetch be", {be1, be0}, 32'h0);
                chk("R11 fetch we", {we1, we0}, 32'h0);
                chk("R11 fetch wdata", wd0 | wd1, 32'h0);
                chk("R11 fetch load", {ld0 | ld1}, 32'h0);
                chk("R11 fetch valid", {lv1, lv0}, 32'h0);
                step();
                if (off == 2) begin
                    mem_pause = 1'b1;
                    mem_rdata = 32'h5555_AAAA;
                    #1;
                    chk("R5 stall data", {st1, st0}, 32'h3);
                    chk("R5 addr data", ma0, data_addr);
                    step();
                    chk("R5 opcode data", op1, prev_op);
                    mem_pause = 1'b0;
                end
                mem_rdata = dw;
                #1;
                chk("R4 data addr u0", ma0, data_addr);
                chk("R4 data addr u1", ma1, data_addr);
                chk("R4 second stall", {st1, st0}, 32'h0);
                // u0 big-endian, u1 little-endian (R10)
                chk("R10 be big", be0, e_be(k, off, 1'b0));
                chk("R10 be little", be1, e_be(k, off, 1'b1));
                if (k == 6) chk("R6 byte wdata", wd0, e_wd(k, sd));
                if (k == 7) chk("R7 half wdata", wd1, e_wd(k, sd));
                if (k >= 6) chk("R8 wdata", wd0 ^ wd1, 32'h0);
                if (k == 8) chk("R8 word wdata", wd0, sd);
                chk("R11 we", {we1, we0}, (k >= 6) ? 32'h3 : 32'h0);
                chk("R9 valid", {lv1, lv0}, (k <= 5) ? 32'h3 : 32'h0);
                chk("R9 load big", ld0, e_ld(k, off, 1'b0, dw));
                chk("R9 load little", ld1, e_ld(k, off, 1'b1, dw));
                step();
                prev_op = fw;
                pc += 4;
            end
        end
        op_kind = 4'd0;
        #1;
        chk("R4 opcode released", op0, prev_op);
        chk("R4 opcode released u1", op1, prev_op);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule